// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block is the processor-facing register bank of a classic 8250-style serial port. A host reaches it through a small request/accept/response slave port that has a 3-bit address, a 3-bit command, 8-bit write data and 8-bit read data. The bank holds the transmit holding byte, the receive buffer byte, the 16-bit baud divisor, the interrupt enable and identification registers, the line control and modem control registers, the line and modem status registers, and a scratch byte. Bit 7 of the line control register is the bank-select bit. When it is set, addresses 0 and 1 reach the divisor instead of the data and interrupt-enable registers.

The serial shifter and the baud generator sit outside the block. The receiver hands over a finished byte with a one-cycle strobe. The transmitter sees a full flag and the holding byte, and reports with a one-cycle pulse when it has taken that byte and with a level while it is still shifting. The divisor and the line control byte are driven out to those neighbours. The block raises one interrupt line from the enabled pending sources. That line is gated by the OUT2 bit of the modem control register.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the registers read as follows, with the bank-select bit (line control bit 7) at 0 unless stated: address 0 returns 00h; address 1 returns 00h; address 2 returns 01h; addresses 3 and 4 return 00h; address 5 returns 60h; addresses 6 and 7 return 00h. With bank-select set, address 0 returns the divisor low byte 02h and address 1 returns the divisor high byte 00h.
- R2: The command codes are idle=000, write=001 and read=010. A write or read is accepted in the same cycle with response 01 (data valid), and a read returns its data in that same cycle. Idle and every other code get no accept and response 00.
- R3: With bank-select at 1, addresses 0 and 1 read and write the divisor low and high bytes, which drive the `divisor` output. With bank-select at 0, address 1 is the interrupt enable register.
- R4: A write to address 0 with bank-select at 0 loads the transmit holding byte. It raises `tx_full` and clears line status bit 5 (holding empty) and bit 6 (transmitter empty). A `tx_take` pulse empties the holding byte and sets bit 5 again. Bit 6 is set only while the holding byte is empty and `tx_busy` is low.
- R5: An `rx_strobe` loads `rx_byte` into the receive buffer and sets line status bit 0 (data ready). A read of address 0 with bank-select at 0 returns that byte and clears bit 0.
- R6: A receive strobe that arrives while data ready is still set, and is not in the same cycle as a receive buffer read, sets line status bit 1 (overrun). A read of the line status register clears it.
- R7: Only interrupt enable bits 1:0 (bit 0 for received data, bit 1 for holding empty) and modem control bit 3 (OUT2) are writable; all other bits of those registers read 0. The modem status register always reads 00h. Writes to addresses 2, 5 and 6 have no effect.
- R8: Address 7 is a read/write scratch byte with no side effect on any other register.
- R9: The identification register (address 2) reads 04h when received data is pending and enabled, otherwise 02h when the holding-empty condition is pending and enabled, otherwise 01h. The holding-empty condition is raised when the transmitter takes a byte, or when enable bit 1 goes from 0 to 1 while the holding byte is empty. It is cleared by a read of address 2 that returns 02h, or by a write to the holding byte.
- R10: `irq_out` is high exactly when OUT2 is set and the identification register reports a pending source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | 3 | Register address |
| req_cmd | input | 3 | Command: idle, write or read |
| req_wdata | input | 8 | Write data |
| cmd_accept | output | 1 | Command accepted this cycle |
| resp_data | output | 8 | Read data |
| resp_code | output | 2 | Response: 00 none, 01 data valid |
| irq_out | output | 1 | Interrupt request |
| rx_strobe | input | 1 | Receiver delivers a byte |
| rx_byte | input | 8 | Received byte |
| tx_take | input | 1 | Transmitter takes the holding byte |
| tx_busy | input | 1 | Transmitter is shifting |
| tx_full | output | 1 | Holding byte is waiting |
| tx_data | output | 8 | Holding byte |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control byte |

## Verification
Accept, response and read data come from the current register state, so they are due in the same cycle as the request. The bench checks them a quarter period after the falling edge on which it drove the request. Any effect of a write, read side effect, receive strobe or take pulse is due one clock later, after the next rising edge. Every later read, or direct look at `irq_out`, `tx_full` or `divisor`, is therefore made in a cycle after that edge. The scoreboard queues the expected response when the driver puts the request on the port, and the monitor pops it in that same sampling slot.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 2 * DATA_W;

    localparam logic [2:0] CMD_IDLE = 3'b000;
    localparam logic [2:0] CMD_WR   = 3'b001;
    localparam logic [2:0] CMD_RD   = 3'b010;

    localparam logic [1:0] RESP_NULL = 2'b00;
    localparam logic [1:0] RESP_DVA  = 2'b01;

    localparam logic [DATA_W-1:0] IIR_NONE = 8'h01;
    localparam logic [DATA_W-1:0] IIR_THRE = 8'h02;
    localparam logic [DATA_W-1:0] IIR_RDA  = 8'h04;

    typedef enum logic [3:0] {
        SEL_RXTX, SEL_IER, SEL_DLL, SEL_DLM, SEL_IIR,
        SEL_LCR, SEL_MCR, SEL_LSR, SEL_MSR, SEL_SCR
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] thr;
        logic [DATA_W-1:0] rbr;
        logic [DATA_W-1:0] dll;
        logic [DATA_W-1:0] dlm;
        logic [1:0]        ier;
        logic [DATA_W-1:0] lcr;
        logic              out2;
        logic [DATA_W-1:0] scr;
        logic              thr_full;
        logic              dr;
        logic              oe;
        logic              thre_flag;
    } bank_t;
endpackage

// File: rtl/uart_ocp_decode.sv
module uart_ocp_decode
    import uart_rb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        cmd,
    input  logic              dlab,
    output reg_sel_e          sel,
    output logic              wr_en,
    output logic              rd_en,
    output logic              accept,
    output logic [1:0]        resp
);
    always_comb begin
        wr_en  = (cmd == CMD_WR);
        rd_en  = (cmd == CMD_RD);
        accept = wr_en | rd_en;
        resp   = accept ? RESP_DVA : RESP_NULL;
        sel    = SEL_SCR;
        case (addr)
            3'd0:    sel = dlab ? SEL_DLL : SEL_RXTX;
            3'd1:    sel = dlab ? SEL_DLM : SEL_IER;
            3'd2:    sel = SEL_IIR;
            3'd3:    sel = SEL_LCR;
            3'd4:    sel = SEL_MCR;
            3'd5:    sel = SEL_LSR;
            3'd6:    sel = SEL_MSR;
            default: sel = SEL_SCR;
        endcase
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_rb_pkg::*;
(
    input  logic              rda_pend,
    input  logic              thre_pend,
    input  logic              out2,
    output logic [DATA_W-1:0] iir,
    output logic              irq
);
    always_comb begin
        if (rda_pend)       iir = IIR_RDA;
        else if (thre_pend) iir = IIR_THRE;
        else                iir = IIR_NONE;
        irq = out2 & (rda_pend | thre_pend);
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RST = 16'h0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_cmd,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cmd_accept,
    output logic [DATA_W-1:0] resp_data,
    output logic [1:0]        resp_code,
    output logic              irq_out,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_take,
    input  logic              tx_busy,
    output logic              tx_full,
    output logic [DATA_W-1:0] tx_data,
    output logic [DIV_W-1:0]  divisor,
    output logic [DATA_W-1:0] line_ctrl
);
    localparam int DLAB_BIT = DATA_W - 1;
    localparam int OUT2_BIT = 3;

    bank_t             s_q, s_d;
    reg_sel_e          sel;
    logic              wr_en, rd_en;
    logic [DATA_W-1:0] iir_val, lsr_val, rd_mux;
    logic              rd_rbr, wr_thr;

    uart_ocp_decode i_dec (
        .addr   (req_addr),
        .cmd    (req_cmd),
        .dlab   (s_q.lcr[DLAB_BIT]),
        .sel    (sel),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .accept (cmd_accept),
        .resp   (resp_code)
    );

    uart_irq_prio i_irq (
        .rda_pend  (s_q.ier[0] & s_q.dr),
        .thre_pend (s_q.ier[1] & s_q.thre_flag),
        .out2      (s_q.out2),
        .iir       (iir_val),
        .irq       (irq_out)
    );

    // Status and read path come from the current state.
    always_comb begin
        lsr_val = {1'b0, (~s_q.thr_full & ~tx_busy), ~s_q.thr_full,
                   3'b000, s_q.oe, s_q.dr};
        rd_mux = '0;
        case (sel)
            SEL_RXTX: rd_mux = s_q.rbr;
            SEL_IER:  rd_mux = {6'b0, s_q.ier};
            SEL_DLL:  rd_mux = s_q.dll;
            SEL_DLM:  rd_mux = s_q.dlm;
            SEL_IIR:  rd_mux = iir_val;
            SEL_LCR:  rd_mux = s_q.lcr;
            SEL_MCR:  rd_mux = {4'b0, s_q.out2, 3'b0};
            SEL_LSR:  rd_mux = lsr_val;
            SEL_MSR:  rd_mux = '0;
            default:  rd_mux = s_q.scr;
        endcase
        resp_data = rd_en ? rd_mux : '0;
    end

    // Next-state computation.
    always_comb begin
        s_d    = s_q;
        rd_rbr = rd_en && (sel == SEL_RXTX);
        wr_thr = wr_en && (sel == SEL_RXTX);

        // read side effects
        if (rd_rbr) s_d.dr = 1'b0;
        if (rd_en && sel == SEL_LSR) s_d.oe = 1'b0;
        if (rd_en && sel == SEL_IIR && iir_val == IIR_THRE) s_d.thre_flag = 1'b0;

        // transmitter takes the holding byte
        if (tx_take && s_q.thr_full) begin
            s_d.thr_full  = 1'b0;
            s_d.thre_flag = 1'b1;
        end

        // receiver delivers a byte
        if (rx_strobe) begin
            s_d.rbr = rx_byte;
            if (s_q.dr && !rd_rbr) s_d.oe = 1'b1;
            s_d.dr = 1'b1;
        end

        // host writes
        if (wr_en) begin
            case (sel)
                SEL_RXTX: begin
                    s_d.thr       = req_wdata;
                    s_d.thr_full  = 1'b1;
                    s_d.thre_flag = 1'b0;
                end
                SEL_IER: begin
                    s_d.ier = req_wdata[1:0];
                    if (!s_q.ier[1] && req_wdata[1] && !s_q.thr_full)
                        s_d.thre_flag = 1'b1;
                end
                SEL_DLL: s_d.dll  = req_wdata;
                SEL_DLM: s_d.dlm  = req_wdata;
                SEL_LCR: s_d.lcr  = req_wdata;
                SEL_MCR: s_d.out2 = req_wdata[OUT2_BIT];
                SEL_SCR: s_d.scr  = req_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.dll       <= DIV_RST[DATA_W-1:0];
            s_q.dlm       <= DIV_RST[DIV_W-1:DATA_W];
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_full   = s_q.thr_full;
    assign tx_data   = s_q.thr;
    assign divisor   = {s_q.dlm, s_q.dll};
    assign line_ctrl = s_q.lcr;

    // Handshake
    assert_read_dva_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd == CMD_RD) |-> (cmd_accept && resp_code == RESP_DVA));
    assert_idle_null_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd == CMD_IDLE) |-> (!cmd_accept && resp_code == RESP_NULL));
    // Transmit holding
    assert_thr_write_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_RXTX) |=> tx_full);
    // Receive buffer
    assert_rbr_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_RXTX && !rx_strobe) |=> !s_q.dr);
    assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && s_q.dr && !(rd_en && sel == SEL_RXTX)) |=> s_q.oe);
    // Interrupt
    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.out2 |-> !irq_out);
    assert_irq_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (iir_val[0] == 1'b0));
endmodule

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
    import uart_rb_pkg::*;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [2:0]  req_cmd = CMD_IDLE;
    logic [7:0]  req_wdata = '0;
    logic        cmd_accept;
    logic [7:0]  resp_data;
    logic [1:0]  resp_code;
    logic        irq_out;
    logic        rx_strobe = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_take = 1'b0;
    logic        tx_busy = 1'b0;
    logic        tx_full;
    logic [7:0]  tx_data;
    logic [15:0] divisor;
    logic [7:0]  line_ctrl;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;

    logic [7:0] exp_data_q[$];
    bit         exp_chk_q[$];
    string      exp_tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    uart_regbank i_uart_regbank (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_cmd(req_cmd),
        .req_wdata(req_wdata), .cmd_accept(cmd_accept), .resp_data(resp_data),
        .resp_code(resp_code), .irq_out(irq_out), .rx_strobe(rx_strobe),
        .rx_byte(rx_byte), .tx_take(tx_take), .tx_busy(tx_busy),
        .tx_full(tx_full), .tx_data(tx_data), .divisor(divisor),
        .line_ctrl(line_ctrl)
    );

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: compares same-cycle responses a quarter period after the driving edge.
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (req_cmd != CMD_IDLE && exp_tag_q.size() > 0) begin
            logic [7:0] ed;
            bit         ec;
            string      et;
            ed = exp_data_q.pop_front();
            ec = exp_chk_q.pop_front();
            et = exp_tag_q.pop_front();
            chk({8'h0, 7'h0, cmd_accept}, 16'h1, {et, " accept"});
            chk({14'h0, resp_code}, {14'h0, RESP_DVA}, {et, " resp"});
            if (ec) chk({8'h0, resp_data}, {8'h0, ed}, {et, " data"});
        end
    end

    task automatic ocp(input logic [2:0] cmd, input logic [2:0] a,
                       input logic [7:0] d, input logic [7:0] exp, input bit ec,
                       input string tag);
        @(negedge clk);
        req_cmd = cmd; req_addr = a; req_wdata = d;
        exp_data_q.push_back(exp); exp_chk_q.push_back(ec); exp_tag_q.push_back(tag);
        @(negedge clk);
        req_cmd = CMD_IDLE;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        ocp(CMD_WR, a, d, 8'h00, 1'b0, tag);
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        ocp(CMD_RD, a, 8'h00, exp, 1'b1, tag);
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk); rx_strobe = 1'b1; rx_byte = b;
        @(negedge clk); rx_strobe = 1'b0;
    endtask

    task automatic take();
        @(negedge clk); tx_take = 1'b1;
        @(negedge clk); tx_take = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #(CLK_P/4);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        settle();
        chk({15'h0, irq_out}, 16'h0, "R1 irq after reset");
        rd(3'd0, 8'h00, "R1 rbr"); rd(3'd1, 8'h00, "R1 ier");
        rd(3'd2, 8'h01, "R1 iir"); rd(3'd3, 8'h00, "R1 lcr");
        rd(3'd4, 8'h00, "R1 mcr"); rd(3'd5, 8'h60, "R1 lsr");
        rd(3'd6, 8'h00, "R1 msr"); rd(3'd7, 8'h00, "R1 scr");
        wr(3'd3, 8'h80, "R3 set bank");
        rd(3'd0, 8'h02, "R1 dll"); rd(3'd1, 8'h00, "R1 dlm");

        // R3 divisor bank
        wr(3'd0, 8'h0C, "R3 dll wr"); wr(3'd1, 8'h01, "R3 dlm wr");
        settle();
        chk(divisor, 16'h010C, "R3 divisor out");
        rd(3'd0, 8'h0C, "R3 dll rd"); rd(3'd1, 8'h01, "R3 dlm rd");
        wr(3'd3, 8'h03, "R3 clear bank");
        rd(3'd1, 8'h00, "R3 ier behind bank");
        rd(3'd3, 8'h03, "R3 lcr rd");
        settle();
        chk({8'h0, line_ctrl}, 16'h0003, "R3 line_ctrl out");

        // R8 scratch
        wr(3'd7, 8'hA5, "R8 scr wr");
        rd(3'd7, 8'hA5, "R8 scr rd"); rd(3'd5, 8'h60, "R8 lsr untouched");
        rd(3'd2, 8'h01, "R8 iir untouched");

        // R7 masks, R9 enable edge
        wr(3'd1, 8'hFF, "R7 ier wr");
        rd(3'd1, 8'h03, "R7 ier mask");
        rd(3'd2, 8'h02, "R9 thre on enable");
        rd(3'd2, 8'h01, "R9 thre cleared by iir read");
        wr(3'd4, 8'hFF, "R7 mcr wr");
        rd(3'd4, 8'h08, "R7 mcr mask");
        wr(3'd6, 8'hFF, "R7 msr wr"); rd(3'd6, 8'h00, "R7 msr fixed");
        wr(3'd5, 8'h00, "R7 lsr wr"); rd(3'd5, 8'h60, "R7 lsr ignores");
        wr(3'd2, 8'hFF, "R7 iir wr"); rd(3'd2, 8'h01, "R7 iir ignores");
        settle();
        chk({15'h0, irq_out}, 16'h0, "R10 nothing pending");

        // R4 transmit holding
        wr(3'd0, 8'h5A, "R4 thr wr");
        settle();
        chk({7'h0, tx_full, tx_data}, 16'h015A, "R4 tx_full/tx_data");
        rd(3'd5, 8'h00, "R4 lsr full");
        tx_busy = 1'b1;
        take();
        settle();
        chk({15'h0, tx_full}, 16'h0, "R4 take empties");
        chk({15'h0, irq_out}, 16'h1, "R10 thre irq");
        rd(3'd5, 8'h20, "R4 lsr shifting");
        rd(3'd2, 8'h02, "R9 thre code");
        settle();
        chk({15'h0, irq_out}, 16'h0, "R10 irq after iir read");
        tx_busy = 1'b0;
        rd(3'd5, 8'h60, "R4 lsr idle");

        // R5 receive, R9 priority
        rx_push(8'h3C);
        settle();
        chk({15'h0, irq_out}, 16'h1, "R10 rda irq");
        rd(3'd2, 8'h04, "R9 rda code");
        wr(3'd0, 8'h11, "R4 thr wr2");
        take();
        rd(3'd2, 8'h04, "R9 rda over thre");
        rd(3'd5, 8'h61, "R5 lsr dr");
        rd(3'd0, 8'h3C, "R5 rbr data");
        rd(3'd5, 8'h60, "R5 dr cleared");
        rd(3'd2, 8'h02, "R9 thre after rda");
        rd(3'd2, 8'h01, "R9 none");

        // R9 clear by holding write
        take();
        wr(3'd1, 8'h01, "R9 ier rda only");
        wr(3'd1, 8'h03, "R9 ier both");
        rd(3'd2, 8'h02, "R9 thre re-armed");
        wr(3'd0, 8'h22, "R9 thr wr clears");
        rd(3'd2, 8'h01, "R9 cleared by thr wr");
        take();
        rd(3'd2, 8'h02, "R9 thre after take");
        rd(3'd2, 8'h01, "R9 drain");

        // R6 overrun
        rx_push(8'h01); rx_push(8'h02);
        rd(3'd5, 8'h63, "R6 overrun set");
        rd(3'd5, 8'h61, "R6 overrun cleared");
        rd(3'd0, 8'h02, "R6 latest byte");
        rd(3'd5, 8'h60, "R6 lsr idle");

        // R10 gating
        rx_push(8'h77);
        wr(3'd4, 8'h00, "R10 out2 off");
        settle();
        chk({15'h0, irq_out}, 16'h0, "R10 gated by out2");
        wr(3'd4, 8'h08, "R10 out2 on");
        settle();
        chk({15'h0, irq_out}, 16'h1, "R10 out2 on irq");
        wr(3'd1, 8'h00, "R10 ier off");
        settle();
        chk({15'h0, irq_out}, 16'h0, "R10 disabled source");
        rd(3'd0, 8'h77, "R5 rbr 77");

        // R2 idle and unknown codes
        settle();
        chk({13'h0, cmd_accept, resp_code}, 16'h0, "R2 idle no accept");
        @(negedge clk); req_cmd = 3'b011; req_addr = 3'd7; req_wdata = 8'hFF;
        #(CLK_P/4);
        chk({13'h0, cmd_accept, resp_code}, 16'h0, "R2 unknown code");
        @(negedge clk); req_cmd = CMD_IDLE;
        rd(3'd7, 8'hA5, "R2 unknown code no write");

        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule